// File: doc/BRIEF.md
# Indirect Management-Bus Register Bridge

This block is a management-bus (MDIO, clause-22 frame style) slave that fronts an internal array of 32 devices by 32 registers of 16 bits each. A five-bit strap input picks its mode. When the strap is zero, the slave answers every bus address, and the PHY and register fields of each frame select one array word directly.

When the strap is nonzero, the slave answers only frames sent to the strapped address. It then exposes two words. Offset 0 is a command/status word and offset 1 is a data word. A host starts an internal cycle by writing a command word that names the target device and register. It polls bit 15 of the status word until the bit drops. For a read, the host then fetches the result from the data word. For a write, it loads the data word before it issues the command.

The internal cycle lasts a parameterised number of clock cycles (`LAT_CYCLES`). Hosts give up after 16 polls, so this latency must stay far below the length of 16 bus frames. The bus clock and data are sampled and synchronised into the system clock domain. The host-side bus clock generator is not part of the block.

Top module: `smi_bridge`

## Requirements
- R1: Frames are decoded on rising edges of the bus clock in this bit order:
  - any number of idle ones;
  - a start pair `0`,`1`;
  - a two-bit opcode (`10` read, `01` write; anything else aborts the frame);
  - a five-bit PHY address, MSB first;
  - a five-bit register address, MSB first;
  - two turnaround bits;
  - sixteen data bits, MSB first.
- R2: With `strap_addr == 0`, a frame to any PHY address reads or writes array word [PHY][register] directly. No command decode takes place, and writing command-like values is plain storage.
- R3: With `strap_addr != 0`, frames whose PHY field differs from the strap never drive `mdio_oe` and change no state.
- R4: In indirect mode, a read of offset 0 returns the busy flag in bit 15 and bits 14:0 of the last accepted command. Offset 1 is the data word. Other offsets read as 0x0000, and writes to them are ignored. Everything reads 0 after reset.
- R5: A command whose bits 15:10 are `100110` (0x9800 | dev<<5 | reg, where dev is bits 9:5 and reg is bits 4:0) copies array word [dev][reg] into the data word when the cycle ends.
- R6: A command whose bits 15:10 are `100101` (0x9400 | dev<<5 | reg) stores the data word into array word [dev][reg] when the cycle ends.
- R7: Busy rises on the clock edge that accepts a valid command. It stays high for exactly `LAT_CYCLES` clock cycles and then clears, so a polling host sees it clear within 16 polls.
- R8: While busy is high, writes to offset 0 and offset 1 are ignored. The stored command and the array are left unchanged.
- R9: A write to offset 0 whose bits 15:10 match neither command code leaves busy low, keeps the stored command, and starts no cycle.
- R10: Reset is synchronous and active high. It clears the array, the command word, the data word and busy, and releases `mdio_oe`.
- R11: On an addressed read, the slave leaves the first turnaround bit undriven and drives 0 in the second. It then drives the sixteen data bits and releases the line after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 5 | Bus address strap; zero selects direct mode |
| mdc | input | 1 | Management bus clock from the host |
| mdio_in | input | 1 | Management data line as seen at the pin |
| mdio_out | output | 1 | Data the slave drives during read data phases |
| mdio_oe | output | 1 | Output enable for `mdio_out` |

## Verification
Bus inputs pass through two synchroniser flops and an edge register. The slave therefore reacts about three clock cycles after each rising edge of `mdc`. The bench holds each bus-clock phase for four clock cycles and samples the line at the end of the low phase, just before the next rising edge, so every driven bit is settled by then.

A write takes effect a few cycles after the sixteenth data bit. A command result is due `LAT_CYCLES` cycles after acceptance, so the bench polls the status word before it reads results. The bench runs with a long latency, which lets a second command and a status read land while busy is still high. The exact busy width is counted cycle by cycle in the bound checker.

// File: rtl/smi_bridge_pkg.sv
package smi_bridge_pkg;

    localparam int DEV_W  = 5;
    localparam int REG_W  = 5;
    localparam int WORD_W = 16;

    localparam logic [1:0] MDIO_OP_RD = 2'b10;
    localparam logic [1:0] MDIO_OP_WR = 2'b01;

    localparam logic [5:0] CMD_RD_CODE = 6'b100110;
    localparam logic [5:0] CMD_WR_CODE = 6'b100101;

    localparam logic [REG_W-1:0] OFS_CMD  = 5'd0;
    localparam logic [REG_W-1:0] OFS_DATA = 5'd1;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_HDR,
        FR_TURN,
        FR_DATA
    } frame_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } cmd_op_e;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [REG_W-1:0] rg;
    } smi_addr_t;

    typedef struct packed {
        logic              valid;
        smi_addr_t         addr;
        logic [WORD_W-1:0] data;
    } bus_wr_t;

    function automatic cmd_op_e decode_cmd(input logic [WORD_W-1:0] w);
        case (w[15:10])
            CMD_RD_CODE: return OP_READ;
            CMD_WR_CODE: return OP_WRITE;
            default:     return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/smi_frame_unit.sv
module smi_frame_unit
    import smi_bridge_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mdc,
    input  logic                    mdio_in,
    input  logic [DEV_W-1:0]        strap_addr,
    input  logic [WORD_W-1:0]       rd_data,
    output smi_addr_t               frm_addr,
    output logic                    frm_sel,
    output bus_wr_t                 wr,
    output logic                    mdio_out,
    output logic                    mdio_oe
);

    logic [2:0]        mdc_q;
    logic [1:0]        dat_q;
    frame_state_e      state;
    logic [3:0]        cnt;
    logic [11:0]       hdr;
    logic [WORD_W-1:0] shreg;
    logic              mdc_rise;
    logic              bit_in;
    logic [1:0]        op;

    assign mdc_rise = mdc_q[1] & ~mdc_q[2];
    assign bit_in   = dat_q[1];
    assign op       = hdr[11:10];
    assign frm_addr = '{dev: hdr[9:5], rg: hdr[4:0]};
    assign frm_sel  = (strap_addr == '0) || (hdr[9:5] == strap_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q <= '0;
            dat_q <= 2'b11;
        end else begin
            mdc_q <= {mdc_q[1:0], mdc};
            dat_q <= {dat_q[0], mdio_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FR_IDLE;
            cnt      <= '0;
            hdr      <= '0;
            shreg    <= '0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b1;
            wr       <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (mdc_rise) begin
                case (state)
                    FR_IDLE: begin
                        if (!bit_in) state <= FR_START;
                    end
                    FR_START: begin
                        cnt   <= '0;
                        state <= bit_in ? FR_HDR : FR_IDLE;
                    end
                    FR_HDR: begin
                        hdr <= {hdr[10:0], bit_in};
                        cnt <= cnt + 4'd1;
                        if (cnt == 4'd11) begin
                            cnt   <= '0;
                            state <= FR_TURN;
                        end
                    end
                    FR_TURN: begin
                        if (op != MDIO_OP_RD && op != MDIO_OP_WR) begin
                            state <= FR_IDLE;
                        end else if (cnt == 4'd0) begin
                            cnt <= 4'd1;
                            if (op == MDIO_OP_RD && frm_sel) begin
                                mdio_oe  <= 1'b1;
                                mdio_out <= 1'b0;
                                shreg    <= rd_data;
                            end
                        end else begin
                            cnt   <= '0;
                            state <= FR_DATA;
                            if (mdio_oe) begin
                                mdio_out <= shreg[15];
                                shreg    <= {shreg[14:0], 1'b0};
                            end
                        end
                    end
                    FR_DATA: begin
                        cnt <= cnt + 4'd1;
                        if (op == MDIO_OP_RD) begin
                            if (mdio_oe) begin
                                if (cnt == 4'd15) begin
                                    mdio_oe  <= 1'b0;
                                    mdio_out <= 1'b1;
                                end else begin
                                    mdio_out <= shreg[15];
                                    shreg    <= {shreg[14:0], 1'b0};
                                end
                            end
                        end else begin
                            shreg <= {shreg[14:0], bit_in};
                            if (cnt == 4'd15 && frm_sel) begin
                                wr <= '{valid: 1'b1, addr: frm_addr,
                                        data: {shreg[14:0], bit_in}};
                            end
                        end
                        if (cnt == 4'd15) state <= FR_IDLE;
                    end
                    default: state <= FR_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/smi_cmd_unit.sv
module smi_cmd_unit
    import smi_bridge_pkg::*;
#(
    parameter int LAT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              wr_valid,
    input  logic [REG_W-1:0]  wr_rg,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] data_word,
    output logic              busy,
    output logic              rf_we,
    output smi_addr_t         rf_addr,
    output logic [WORD_W-1:0] rf_wdata
);

    localparam int               CNT_W    = $clog2(LAT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(LAT_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0]  cnt;
    cmd_op_e           pend_op;
    logic [14:0]       cmd_q;
    logic [WORD_W-1:0] data_q;
    logic              last;
    cmd_op_e           new_op;

    assign last        = busy && (cnt == CNT_ONE);
    assign new_op      = decode_cmd(wr_data);
    assign status_word = {busy, cmd_q};
    assign data_word   = data_q;
    assign rf_we       = last && (pend_op == OP_WRITE);
    assign rf_wdata    = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            pend_op <= OP_NONE;
            cmd_q   <= '0;
            data_q  <= '0;
            rf_addr <= '0;
        end else if (busy) begin
            cnt <= cnt - CNT_ONE;
            if (last) begin
                busy <= 1'b0;
                if (pend_op == OP_READ) data_q <= rf_rdata;
            end
        end else if (enable && wr_valid) begin
            if (wr_rg == OFS_CMD) begin
                if (new_op != OP_NONE) begin
                    busy    <= 1'b1;
                    cnt     <= LAT_LOAD;
                    pend_op <= new_op;
                    cmd_q   <= wr_data[14:0];
                    rf_addr <= '{dev: wr_data[9:5], rg: wr_data[4:0]};
                end
            end else if (wr_rg == OFS_DATA) begin
                data_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/smi_regfile.sv
module smi_regfile
    import smi_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  smi_addr_t         waddr,
    input  logic [WORD_W-1:0] wdata,
    input  smi_addr_t         raddr_a,
    output logic [WORD_W-1:0] rdata_a,
    input  smi_addr_t         raddr_b,
    output logic [WORD_W-1:0] rdata_b
);

    localparam int ENTRIES = 1 << (DEV_W + REG_W);

    logic [WORD_W-1:0] mem [ENTRIES];

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/smi_bridge.sv
module smi_bridge
    import smi_bridge_pkg::*;
#(
    parameter int LAT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] strap_addr,
    input  logic       mdc,
    input  logic       mdio_in,
    output logic       mdio_out,
    output logic       mdio_oe
);

    logic              direct;
    smi_addr_t         frm_addr;
    logic              frm_sel;
    bus_wr_t           bus_wr;
    logic [WORD_W-1:0] rd_data;
    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] data_word;
    logic              busy;
    logic              cu_we;
    smi_addr_t         cu_addr;
    logic [WORD_W-1:0] cu_wdata;
    logic              rf_we;
    smi_addr_t         rf_waddr;
    logic [WORD_W-1:0] rf_wdata;
    logic [WORD_W-1:0] rf_rdata_a;
    logic [WORD_W-1:0] rf_rdata_b;

    assign direct = (strap_addr == '0);

    smi_frame_unit u_frame (
        .clk        (clk),
        .rst        (rst),
        .mdc        (mdc),
        .mdio_in    (mdio_in),
        .strap_addr (strap_addr),
        .rd_data    (rd_data),
        .frm_addr   (frm_addr),
        .frm_sel    (frm_sel),
        .wr         (bus_wr),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    smi_cmd_unit #(.LAT_CYCLES(LAT_CYCLES)) u_cmd (
        .clk         (clk),
        .rst         (rst),
        .enable      (!direct),
        .wr_valid    (bus_wr.valid),
        .wr_rg       (bus_wr.addr.rg),
        .wr_data     (bus_wr.data),
        .rf_rdata    (rf_rdata_b),
        .status_word (status_word),
        .data_word   (data_word),
        .busy        (busy),
        .rf_we       (cu_we),
        .rf_addr     (cu_addr),
        .rf_wdata    (cu_wdata)
    );

    always_comb begin
        if (direct) begin
            rf_we    = bus_wr.valid;
            rf_waddr = bus_wr.addr;
            rf_wdata = bus_wr.data;
        end else begin
            rf_we    = cu_we;
            rf_waddr = cu_addr;
            rf_wdata = cu_wdata;
        end
    end

    always_comb begin
        if (direct)                     rd_data = rf_rdata_a;
        else if (frm_addr.rg == OFS_CMD)  rd_data = status_word;
        else if (frm_addr.rg == OFS_DATA) rd_data = data_word;
        else                            rd_data = '0;
    end

    smi_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (frm_addr),
        .rdata_a (rf_rdata_a),
        .raddr_b (cu_addr),
        .rdata_b (rf_rdata_b)
    );

endmodule

// File: rtl/smi_bridge_chk.sv
module smi_bridge_chk #(
    parameter int LAT_CYCLES = 4
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  strap_addr,
    input logic        mdio_oe,
    input logic        frm_sel,
    input logic        busy,
    input logic [15:0] status_word,
    input logic        rf_we,
    input logic        wr_valid,
    input logic [4:0]  wr_rg,
    input logic [15:0] wr_data
);

    int  busy_len;
    logic valid_cmd_wr;

    assign valid_cmd_wr = wr_valid && (wr_rg == 5'd0) &&
                          (wr_data[15:10] == 6'b100110 || wr_data[15:10] == 6'b100101);

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R3: the line is only driven for frames this slave answers
    a_r3_drive_only_selected: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> frm_sel);

    // R7: busy stays high exactly LAT_CYCLES cycles
    a_r7_busy_width: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy)) |-> (busy_len == LAT_CYCLES));

    // R8: the stored command cannot change while busy
    a_r8_cmd_held_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(status_word[14:0]));

    // R9: busy only rises after a write of a valid command code to offset 0
    a_r9_busy_needs_code: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(valid_cmd_wr));

    // R6: in indirect mode the array is written only inside an internal cycle
    a_r6_array_write_in_cycle: assert property (@(posedge clk) disable iff (rst)
        (strap_addr != 5'd0 && rf_we) |-> busy);

    // R2: direct mode never starts an internal cycle
    a_r2_direct_no_busy: assert property (@(posedge clk) disable iff (rst)
        (strap_addr == 5'd0 && $stable(strap_addr)) |=> !$rose(busy));

endmodule

bind smi_bridge smi_bridge_chk #(.LAT_CYCLES(LAT_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .strap_addr  (strap_addr),
    .mdio_oe     (mdio_oe),
    .frm_sel     (frm_sel),
    .busy        (busy),
    .status_word (status_word),
    .rf_we       (rf_we),
    .wr_valid    (bus_wr.valid),
    .wr_rg       (bus_wr.addr.rg),
    .wr_data     (bus_wr.data)
);

// File: tb/tb_smi_bridge.sv
module tb_smi_bridge;

    localparam int LAT = 600;
    localparam logic [4:0] MYADDR = 5'd5;
    localparam int NVEC = 6;
    // {device, register, value}
    localparam logic [25:0] VEC [NVEC] = '{
        {5'd3,  5'd4,  16'h1234},
        {5'd0,  5'd0,  16'hFFFF},
        {5'd31, 5'd31, 16'h8001},
        {5'd5,  5'd0,  16'h00A5},
        {5'd17, 5'd9,  16'h7E7E},
        {5'd31, 5'd0,  16'h0F0F}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] strap = MYADDR;
    logic       mdc = 1'b0;
    logic       host_oe = 1'b1;
    logic       host_drv = 1'b1;
    logic       mdio_out;
    logic       mdio_oe;
    logic       line;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign line = host_oe ? host_drv : (mdio_oe ? mdio_out : 1'b1);

    smi_bridge #(.LAT_CYCLES(LAT)) dut (
        .clk        (clk),
        .rst        (rst),
        .strap_addr (strap),
        .mdc        (mdc),
        .mdio_in    (line),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        mdc = 1'b0; host_oe = 1'b1; host_drv = b;
        half();
        mdc = 1'b1;
        half();
    endtask

    task automatic send_hdr(input int pre, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(rg[i]);
    endtask

    task automatic mdio_write(input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] d, input int pre = 2);
        send_hdr(pre, 2'b01, phy, rg);
        send_bit(1'b1); send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
        mdc = 1'b0; host_drv = 1'b1;
        half();
    endtask

    task automatic mdio_read(input logic [4:0] phy, input logic [4:0] rg,
                             output logic [15:0] d, output logic drv, output logic ta_ok);
        logic t1, t2, rel;
        send_hdr(2, 2'b10, phy, rg);
        host_oe = 1'b0;
        mdc = 1'b0; half(); t1 = mdio_oe; drv = mdio_oe;
        mdc = 1'b1; half();
        mdc = 1'b0; half(); t2 = mdio_oe && (mdio_out == 1'b0); drv = drv | mdio_oe;
        mdc = 1'b1; half();
        for (int i = 15; i >= 0; i--) begin
            mdc = 1'b0; half();
            d[i] = line; drv = drv | mdio_oe;
            mdc = 1'b1; half();
        end
        mdc = 1'b0; half();
        rel = !mdio_oe;
        ta_ok = !t1 && t2 && rel;
        host_oe = 1'b1; host_drv = 1'b1;
    endtask

    task automatic rd(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] d);
        logic drv, ta;
        mdio_read(phy, rg, d, drv, ta);
    endtask

    task automatic poll(output int n, output logic [15:0] st);
        n = 0;
        do begin
            rd(MYADDR, 5'd0, st);
            n++;
        end while (st[15] && n < 16);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d, st;
        logic drv, ta;
        int n;
        logic [15:0] cmd;

        do_reset();
        // R10: reset state
        check("R10 oe after reset", {15'd0, mdio_oe}, 16'h0);
        mdio_read(MYADDR, 5'd0, d, drv, ta);
        check("R10 status after reset", d, 16'h0000);
        check("R11 turnaround and release", {15'd0, ta}, 16'h1);
        rd(MYADDR, 5'd1, d);
        check("R10 data word after reset", d, 16'h0000);

        // R4: unused offset
        mdio_write(MYADDR, 5'd2, 16'hFFFF);
        rd(MYADDR, 5'd2, d);
        check("R4 unused offset reads zero", d, 16'h0000);

        // R3: unaddressed frames
        mdio_read(5'd7, 5'd0, d, drv, ta);
        check("R3 no drive for other address", {15'd0, drv}, 16'h0);
        mdio_write(5'd7, 5'd1, 16'h5A5A);
        rd(MYADDR, 5'd1, d);
        check("R3 other-address write ignored", d, 16'h0000);

        // R1: long preamble accepted
        mdio_write(MYADDR, 5'd1, 16'hC3C3, 32);
        rd(MYADDR, 5'd1, d);
        check("R1 long preamble frame", d, 16'hC3C3);

        // R5/R6: vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0] dv, rg;
            logic [15:0] val;
            {dv, rg, val} = VEC[v];
            mdio_write(MYADDR, 5'd1, val);
            cmd = 16'h9400 | {6'd0, dv, rg};
            mdio_write(MYADDR, 5'd0, cmd);
            poll(n, st);
            check("R7 write cycle clears within 16 polls", {15'd0, st[15]}, 16'h0);
            check("R4 status holds last command", st, {1'b0, cmd[14:0]});
            mdio_write(MYADDR, 5'd1, 16'h0000);
            cmd = 16'h9800 | {6'd0, dv, rg};
            mdio_write(MYADDR, 5'd0, cmd);
            poll(n, st);
            mdio_read(MYADDR, 5'd1, d, drv, ta);
            check("R5 R6 indirect round trip", d, val);
            check("R11 turnaround on data read", {15'd0, ta}, 16'h1);
        end

        // R9: unknown command codes
        rd(MYADDR, 5'd0, st);
        mdio_write(MYADDR, 5'd0, 16'h1C63);
        rd(MYADDR, 5'd0, d);
        check("R9 code 000111 ignored", d, st);
        mdio_write(MYADDR, 5'd0, 16'h9C00);
        rd(MYADDR, 5'd0, d);
        check("R9 code 100111 ignored", d, st);

        // R7/R8: command while busy
        mdio_write(MYADDR, 5'd1, 16'h4321);
        mdio_write(MYADDR, 5'd0, 16'h9508);
        mdio_write(MYADDR, 5'd0, 16'h9529);
        rd(MYADDR, 5'd0, d);
        check("R7 busy seen during cycle", d, 16'h9508);
        poll(n, st);
        check("R8 second command dropped", st, 16'h1508);
        mdio_write(MYADDR, 5'd0, 16'h9800 | 16'h0129);
        poll(n, st);
        rd(MYADDR, 5'd1, d);
        check("R8 ignored target untouched", d, 16'h0000);
        mdio_write(MYADDR, 5'd0, 16'h9800 | 16'h0108);
        poll(n, st);
        rd(MYADDR, 5'd1, d);
        check("R7 accepted write landed", d, 16'h4321);

        // R2: direct mode
        strap = 5'd0;
        do_reset();
        rd(5'd9, 5'd17, d);
        check("R2 direct reset value", d, 16'h0000);
        mdio_write(5'd9, 5'd17, 16'hA5A5);
        mdio_write(5'd0, 5'd0, 16'h9821);
        rd(5'd9, 5'd17, d);
        check("R2 direct word stored", d, 16'hA5A5);
        rd(5'd0, 5'd0, d);
        check("R2 command-like value stored plainly", d, 16'h9821);
        mdio_read(5'd0, 5'd1, d, drv, ta);
        check("R2 no command executed", d, 16'h0000);
        check("R2 direct answers any address", {15'd0, drv}, 16'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule